// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a converter front end with two banks of four simultaneously sampled channels. A host talks to it over one shared, bidirectional 14-bit parallel bus. A write cycle loads a 4-bit mode word into the low bus bits. A read cycle drives a 14-bit conversion result onto the whole bus. The chip-select, write and read strobes are active low, and the core samples them on its own clock.

The mode word chooses three things: a bank, a channel count from one to four, and a power-down flag. A rising edge on the active-low convert-start input freezes the mode and launches a sequence. The sequence raises a request to an external converter once per channel, in ascending channel order. Each returned word goes into a four-slot result buffer. When the last channel is stored, the active-low interrupt falls. The host then reads the slots one by one on successive read cycles, and the first read releases the interrupt.

Top module: `sampleSeqCore`

## Requirements
- R1: A mode word is taken from bus bits [3:0] while chip-select and write are both low. It takes effect at the first clock on which either strobe has returned high.
- R2: While chip-select is high, write and read strobes have no effect. The mode does not change, the read slot pointer does not move, the interrupt is not released, and the core does not drive the bus.
- R3: After reset the mode is bank A with a single channel, and the interrupt is high.
- R4: Mode word encoding: bits [1:0] hold the channel count minus one, bit 2 selects bank B when 1, and bit 3 set means power-down.
- R5: A mode stays in force for any number of sequences until a new mode word is written.
- R6: A sequence starts on the clock after convert-start goes from low to high, and the core then raises its converter request.
- R7: Channels are requested in the order 0, 1, …, count−1. The selected bank is presented with each request, and exactly count requests are made.
- R8: The interrupt falls on the clock after the converter returns the last channel's word, and not before.
- R9: A convert-start rising edge that arrives during a sequence does not restart it. The core instead raises a one-cycle error pulse.
- R10: Successive reads with chip-select low drive slot 0, 1, 2, … of the result buffer onto the bus. The interrupt returns high after the first completed read.
- R11: In power-down mode, convert-start is ignored. No request is made and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| dataBus | inout | 14 | Shared mode-in / result-out bus |
| convStN | input | 1 | Convert start, active low, acts on its rising edge |
| convReq | output | 1 | Request to the converter, held until done |
| convChan | output | 2 | Channel index of the current request |
| convBank | output | 1 | Bank of the current request (1 = B) |
| convDone | input | 1 | One-cycle pulse: converter word is valid |
| convData | input | 14 | Converted word |
| intN | output | 1 | End-of-sequence interrupt, active low |
| seqErr | output | 1 | One-cycle pulse on a convert-start while busy |

## Verification
The hardest case to reach from the ports is a convert-start edge that lands in the middle of a four-channel sequence. That edge must leave the channel index and request stream untouched. The bench reaches it by using a converter model with a fixed multi-cycle latency, which keeps each sequence busy for many cycles. It then pulses convert-start a few cycles after launch and checks three things: the error pulse count, the total request count, and the order of the channels requested. Ignored strobes under a high chip-select are shown at the ports by the next sequence's channel count and by the slot that a later read returns.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DATA_W = 14;
  localparam int MODE_W = 4;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  // Mode word layout: [3] power-down, [2] bank B, [1:0] count minus one
  typedef struct packed {
    logic            pwrDown;
    logic            bankB;
    logic [CH_W-1:0] cntM1;
  } modeWord_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seqState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic            clrPtr;
    logic            store;
    logic [CH_W-1:0] slot;
  } dpStrobe_t;
endpackage

// File: rtl/seqData.sv
module seqData
  import seq_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int MW    = MODE_W,
  parameter int SLOTS = NUM_CH
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          wrN,
  input  logic          rdN,
  input  logic [MW-1:0] modeIn,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] convData,
  output modeWord_t     mode,
  output logic          readDone,
  output logic          busOe,
  output logic [DW-1:0] busOut
);
  localparam int PW = $clog2(SLOTS);

  logic          wrArm;
  logic          rdArm;
  logic [MW-1:0] shadow;
  modeWord_t     modeReg;
  logic [PW-1:0] rdPtr;
  logic [DW-1:0] slotMem [SLOTS];
  logic          writeCommit;

  assign writeCommit = wrArm && (csN || wrN);
  assign readDone    = rdArm && (csN || rdN);
  assign mode        = modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrArm   <= 1'b0;
      rdArm   <= 1'b0;
      shadow  <= '0;
      modeReg <= '0;
    end else begin
      wrArm <= !csN && !wrN;
      rdArm <= !csN && !rdN;
      if (!csN && !wrN) shadow <= modeIn;
      if (writeCommit) modeReg <= modeWord_t'(shadow);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPtr <= '0;
    else if (strobe.clrPtr) rdPtr <= '0;
    else if (readDone) rdPtr <= rdPtr + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotMem[g] <= '0;
      else if (strobe.store && (strobe.slot == PW'(g))) slotMem[g] <= convData;
    end
  end

  assign busOe  = !csN && !rdN;
  assign busOut = slotMem[rdPtr];

  AST_CS_HIGH_NO_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !wrArm) |=> $stable(modeReg)); // R2
  AST_CS_HIGH_NO_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !rdArm && !strobe.clrPtr) |=> $stable(rdPtr)); // R2
  AST_WRITE_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrArm && wrN && !csN) |=> (modeReg == $past(shadow))); // R1
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seq_pkg::*;
#(
  parameter int CHANS = NUM_CH
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            convStN,
  input  modeWord_t       mode,
  input  logic            convDone,
  input  logic            readDone,
  output dpStrobe_t       strobe,
  output logic            convReq,
  output logic [CH_W-1:0] convChan,
  output logic            convBank,
  output logic            intN,
  output logic            seqErr
);
  seqState_t       state;
  logic [CH_W-1:0] idx;
  logic [CH_W-1:0] lastIdx;
  logic            bankLat;
  logic            convStPrev;
  logic            startEv;
  logic            launch;

  assign startEv = convStN && !convStPrev;
  assign launch  = (state == ST_IDLE) && startEv && !mode.pwrDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      lastIdx    <= '0;
      bankLat    <= 1'b0;
      convStPrev <= 1'b1;
      intN       <= 1'b1;
      seqErr     <= 1'b0;
    end else begin
      convStPrev <= convStN;
      seqErr     <= 1'b0;
      if (readDone) intN <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state   <= ST_BUSY;
            idx     <= '0;
            lastIdx <= mode.cntM1;
            bankLat <= mode.bankB;
            intN    <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (startEv) seqErr <= 1'b1;
          if (convDone) begin
            if (idx == lastIdx) begin
              state <= ST_IDLE;
              intN  <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clrPtr = launch;
    strobe.store  = (state == ST_BUSY) && convDone;
    strobe.slot   = idx;
  end

  assign convReq  = (state == ST_BUSY);
  assign convChan = idx;
  assign convBank = bankLat;

  AST_INT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(convDone && (idx == lastIdx))); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_BUSY) && startEv && !convDone) |=> $stable(idx)); // R9
  AST_PD_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> !$past(mode.pwrDown)); // R11
  AST_FIRST_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> (convChan == '0)); // R7
  AST_CHAN_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && $past(convReq) && !$stable(convChan)) |->
      (convChan == CH_W'($past(convChan) + 1'b1))); // R7
endmodule

// File: rtl/sampleSeqCore.sv
module sampleSeqCore
  import seq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int MW = MODE_W,
  parameter int CW = CH_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          wrN,
  input  logic          rdN,
  inout  wire  [DW-1:0] dataBus,
  input  logic          convStN,
  output logic          convReq,
  output logic [CW-1:0] convChan,
  output logic          convBank,
  input  logic          convDone,
  input  logic [DW-1:0] convData,
  output logic          intN,
  output logic          seqErr
);
  modeWord_t     mode;
  dpStrobe_t     strobe;
  logic          readDone;
  logic          busOe;
  logic [DW-1:0] busOut;

  assign dataBus = busOe ? busOut : 'z;

  seqData #(.DW(DW), .MW(MW), .SLOTS(NUM_CH)) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .modeIn(dataBus[MW-1:0]), .strobe(strobe), .convData(convData),
    .mode(mode), .readDone(readDone), .busOe(busOe), .busOut(busOut)
  );

  seqCtrl #(.CHANS(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .convStN(convStN), .mode(mode),
    .convDone(convDone), .readDone(readDone), .strobe(strobe),
    .convReq(convReq), .convChan(convChan), .convBank(convBank),
    .intN(intN), .seqErr(seqErr)
  );
endmodule

// File: tb/tb_sampleSeqCore.sv
module tb_sampleSeqCore;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MODES [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, convStN = 1'b1;
  logic [13:0] busDrv = '0;
  logic busDrvEn = 1'b0;
  wire  [13:0] dataBus;
  logic convReq, convBank, convDone, intN, seqErr;
  logic [1:0] convChan;
  logic [13:0] convData;

  int checks = 0, errors = 0;
  int reqCount = 0, errSeen = 0, lat = 0;
  int reqChan [16];
  int reqBank [16];
  logic [8:0] seqTag = '0;

  assign dataBus = busDrvEn ? busDrv : 'z;
  always #(CLK_PERIOD/2) clk = ~clk;

  sampleSeqCore dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .dataBus(dataBus),
    .convStN(convStN), .convReq(convReq), .convChan(convChan), .convBank(convBank),
    .convDone(convDone), .convData(convData), .intN(intN), .seqErr(seqErr)
  );

  // Converter model: fixed latency, tagged words, request log
  always @(posedge clk) begin
    if (!rstN) begin
      convDone <= 1'b0; convData <= '0; lat <= 0;
    end else begin
      convDone <= 1'b0;
      if (seqErr) errSeen <= errSeen + 1;
      if (convReq && !convDone) begin
        if (lat == 2) begin
          convDone <= 1'b1;
          convData <= {convBank, seqTag, 2'b00, convChan};
          if (reqCount < 16) begin
            reqChan[reqCount] = int'(convChan);
            reqBank[reqCount] = int'(convBank);
          end
          reqCount <= reqCount + 1;
          lat <= 0;
        end else lat <= lat + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic [3:0] m, input bit csFirst);
    @(negedge clk); csN = 0; wrN = 0; busDrv = {10'd0, m}; busDrvEn = 1;
    @(negedge clk);
    if (csFirst) csN = 1; else wrN = 1;
    @(negedge clk); csN = 1; wrN = 1; busDrvEn = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); convStN = 0;
    @(negedge clk); convStN = 1;
  endtask

  task automatic readSlot(output logic [13:0] v);
    @(negedge clk); csN = 0; rdN = 0;
    @(negedge clk); v = dataBus; csN = 1; rdN = 1;
    @(negedge clk);
  endtask

  task automatic waitInt();
    for (int i = 0; i < 300 && intN; i++) @(negedge clk);
  endtask

  // Launch a sequence and check its requests, interrupt and results
  task automatic runSeq(input int expCnt, input int expBank, input string tag);
    logic [13:0] v;
    seqTag = seqTag + 1'b1;
    reqCount = 0;
    pulseStart();
    waitInt();
    check(intN == 1'b0, "R8 interrupt low at end", int'(intN), 0);
    check(reqCount == expCnt, {tag, " R7 request count"}, reqCount, expCnt);
    for (int k = 0; k < expCnt && k < reqCount; k++) begin
      check(reqChan[k] == k, {tag, " R7 channel order"}, reqChan[k], k);
      check(reqBank[k] == expBank, {tag, " R7 bank"}, reqBank[k], expBank);
    end
    for (int k = 0; k < expCnt; k++) begin
      readSlot(v);
      check(v == {expBank[0], seqTag, 2'b00, 2'(k)}, {tag, " R10 slot data"}, int'(v),
            int'({expBank[0], seqTag, 2'b00, 2'(k)}));
      if (k == 0) check(intN == 1'b1, "R10 interrupt released by first read", int'(intN), 1);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R3: reset state
    check(intN == 1'b1, "R3 interrupt high after reset", int'(intN), 1);
    check(convReq == 1'b0, "R3 no request after reset", int'(convReq), 0);
    check(seqErr == 1'b0, "R3 no error after reset", int'(seqErr), 0);
    runSeq(1, 0, "R3 default mode");

    // R4/R1/R6: every mode from the vector table
    foreach (MODES[i]) begin
      writeMode(MODES[i], i % 2 == 1);
      runSeq(int'(MODES[i][1:0]) + 1, int'(MODES[i][2]), "R4 R1 R6 table");
    end

    // R5: mode persists across sequences
    writeMode(4'h3, 1'b0);
    runSeq(4, 0, "R5 first");
    runSeq(4, 0, "R5 second");

    // R2: write with chip-select high is ignored
    @(negedge clk); wrN = 0; busDrv = 14'h4; busDrvEn = 1;
    @(negedge clk); wrN = 1; busDrvEn = 0;
    runSeq(4, 0, "R2 ignored write");

    // R2: read with chip-select high is ignored
    seqTag = seqTag + 1'b1; reqCount = 0;
    pulseStart(); waitInt();
    @(negedge clk); rdN = 0;
    @(negedge clk); rdN = 1;
    @(negedge clk);
    check(intN == 1'b0, "R2 read with cs high keeps interrupt", int'(intN), 0);
    readSlot(v);
    check(v == {1'b0, seqTag, 2'b00, 2'd0}, "R2 pointer not moved", int'(v),
          int'({1'b0, seqTag, 2'b00, 2'd0}));

    // R9: convert-start while busy
    e0 = errSeen;
    seqTag = seqTag + 1'b1; reqCount = 0;
    pulseStart();
    repeat (4) @(negedge clk);
    pulseStart();
    waitInt();
    check(errSeen - e0 == 1, "R9 error pulse count", errSeen - e0, 1);
    check(reqCount == 4, "R9 no restart request count", reqCount, 4);
    for (int k = 0; k < 4; k++)
      check(reqChan[k] == k, "R9 channel order kept", reqChan[k], k);
    for (int k = 0; k < 4; k++) readSlot(v);

    // R11: power-down ignores convert-start
    writeMode(4'hB, 1'b0);
    e0 = errSeen; reqCount = 0;
    pulseStart();
    repeat (40) @(negedge clk);
    check(reqCount == 0, "R11 no request in power-down", reqCount, 0);
    check(intN == 1'b1, "R11 interrupt stays high", int'(intN), 1);
    check(errSeen == e0, "R11 no error in power-down", errSeen - e0, 0);
    writeMode(4'h6, 1'b1);
    runSeq(3, 1, "R11 resume");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule